// File: doc/BRIEF.md
# Duplex LCD Segment Driver

This block drives a two-common multiplexed liquid-crystal panel with 23 segment pins. Every segment pin carries two display elements, one shown while common 0 is selected and one shown while common 1 is selected, so the panel holds 46 elements. Software-side logic writes the panel through a write strobe that carries a digit index and a 4-bit value. A mode bit picks how the value is stored. It can be stored as raw element bits, or it can be expanded through an internal seven-segment decoder into a full eight-bit digit pattern.

The frame timer advances only on a prescaled tick-enable input. One complete frame runs through four phases: each common is selected once with positive polarity and once with negative polarity, so the panel sees no net DC. Each common is reported as a 2-bit level code, and a later analog stage turns that code into the half-bias voltages. Each segment is a single logic level. New data is written into a staging buffer and reaches the display buffer only at a frame boundary. A standby input drives every output low.

Top module: `lcdDuplexDriver`

## Requirements
- R1: After reset the display buffer is all zero (blank). The timer starts in phase 0, so common 0 shows high (2'b10), common 1 shows mid (2'b01), and every segment output is 1.
- R2: Level codes are low 2'b00, mid 2'b01 and high 2'b10. Phases run in the order 0,1,2,3 and then repeat. Phase p selects common p%2, and phases 2 and 3 are the negative ones. The selected common is high in a positive phase and low in a negative phase, and the unselected common is mid. Each phase lasts TICKS_PER_PHASE tickEn pulses, which is TICK_HZ/(4*FRAME_HZ), so one frame takes 10 ms at the nominal tick rate.
- R3: A segment whose element for the selected common is on drives 0 in positive phases and 1 in negative phases. An element that is off drives the same level as the selected common: 1 in positive phases and 0 in negative phases.
- R4: Element bit k belongs to segment pin k/2 during common k%2. A direct write (wrConv=0) to digit d stores bit j of wrData into element bit 4d+j.
- R5: A converted write (wrConv=1) to digit d decodes wrData into segments a..g and stores them as element bits 4d+0..4d+6. Element bit 4d+7 is cleared. The codes for values 0..F, in hex, are 3F,06,5B,4F,66,6D,7D,07,7F,6F,77,7C,39,5E,79,71.
- R6: A converted write to the last digit (11) keeps only its low four bits. A write to any digit index of 12 or more changes nothing.
- R7: A write changes the outputs only from the start of the next phase 0 after the write, which follows the last tick of phase 3. If a write lands in the same cycle as that last tick, it waits one further frame.
- R8: While standby is high, every segment output is 0 and both commons are low (2'b00). The frame timer keeps counting. When standby drops, normal drive resumes in whatever phase the timer has reached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | Prescaled frame-timer tick |
| standby | input | 1 | Forces all outputs low |
| wrEn | input | 1 | Write strobe |
| wrConv | input | 1 | 1: seven-segment decoded write, 0: direct write |
| wrDigit | input | 4 | Digit index of the write |
| wrData | input | 4 | Value written |
| segOut | output | 23 | Segment pin levels |
| com0Lvl | output | 2 | Level code of common 0 |
| com1Lvl | output | 2 | Level code of common 1 |

## Verification
The hardest situation to reach is a write that lands in exactly the cycle of the last tick of phase 3, where staging and display update on the same edge. The bench keeps its own count of ticks and phases. It steps single ticks until its count reaches that final tick, then issues the write and the tick together. It checks that the old pattern survives a whole frame and that the new one appears in the frame after. A converted write into the top digit is also driven on purpose, to show that the half of the pattern above the buffer is dropped.

// File: rtl/lcdDuplexPkg.sv
package lcdDuplexPkg;

  typedef enum logic [1:0] {
    LVL_LOW  = 2'b00,
    LVL_MID  = 2'b01,
    LVL_HIGH = 2'b10
  } lcdLevel_e;

  // Strobes from the frame controller to the datapath
  typedef struct packed {
    logic frameLoad;  // copy staging to display at this edge
    logic comSel;     // common selected in the current phase
    logic negPhase;   // polarity of the current phase
  } lcdStrobe_t;

  // Seven-segment decode, bit 0 = segment a ... bit 6 = segment g
  function automatic logic [6:0] segDecode(input logic [3:0] value);
    case (value)
      4'h0: segDecode = 7'h3F;
      4'h1: segDecode = 7'h06;
      4'h2: segDecode = 7'h5B;
      4'h3: segDecode = 7'h4F;
      4'h4: segDecode = 7'h66;
      4'h5: segDecode = 7'h6D;
      4'h6: segDecode = 7'h7D;
      4'h7: segDecode = 7'h07;
      4'h8: segDecode = 7'h7F;
      4'h9: segDecode = 7'h6F;
      4'hA: segDecode = 7'h77;
      4'hB: segDecode = 7'h7C;
      4'hC: segDecode = 7'h39;
      4'hD: segDecode = 7'h5E;
      4'hE: segDecode = 7'h79;
      default: segDecode = 7'h71;
    endcase
  endfunction

endpackage

// File: rtl/lcdDuplexCtrl.sv
module lcdDuplexCtrl
  import lcdDuplexPkg::*;
#(
  parameter int TICKS_PER_PHASE = 4,
  localparam int CNT_W = (TICKS_PER_PHASE > 1) ? $clog2(TICKS_PER_PHASE) : 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tickEn,
  output lcdStrobe_t strobe
);

  logic [CNT_W-1:0] tickCnt;
  logic [1:0]       phase;
  logic             lastTick;

  assign lastTick = tickEn && (tickCnt == CNT_W'(TICKS_PER_PHASE - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tickCnt <= '0;
      phase   <= 2'd0;
    end else if (lastTick) begin
      tickCnt <= '0;
      phase   <= phase + 2'd1;
    end else if (tickEn) begin
      tickCnt <= tickCnt + 1'b1;
    end
  end

  always_comb begin
    strobe.frameLoad = lastTick && (phase == 2'd3);
    strobe.comSel    = phase[0];
    strobe.negPhase  = phase[1];
  end

  // R2: the phase only moves on a tick
  p_phase_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tickEn |=> $stable(phase));

  // R7: a frame load always starts the next frame in phase 0
  p_load_wraps_r7: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.frameLoad |=> (phase == 2'd0));

endmodule

// File: rtl/lcdDuplexData.sv
module lcdDuplexData
  import lcdDuplexPkg::*;
#(
  parameter int NUM_SEG = 23,
  localparam int PLANE_W    = 2 * NUM_SEG,
  localparam int NUM_DIGITS = (PLANE_W + 3) / 4,
  localparam int BUF_W      = 4 * NUM_DIGITS,
  localparam int DIGIT_W    = $clog2(NUM_DIGITS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               standby,
  input  logic               wrEn,
  input  logic               wrConv,
  input  logic [DIGIT_W-1:0] wrDigit,
  input  logic [3:0]         wrData,
  input  lcdStrobe_t         strobe,
  output logic [NUM_SEG-1:0] segOut,
  output logic [1:0]         com0Lvl,
  output logic [1:0]         com1Lvl
);

  logic [BUF_W-1:0] stageBuf;
  logic [BUF_W-1:0] dispBuf;
  logic [7:0]       pattern;

  assign pattern = {1'b0, segDecode(wrData)};

  // Staging buffer, one nibble per digit; a decoded write also fills the next digit
  for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_digit
    logic lowHit;
    logic highHit;
    assign lowHit = wrEn && (wrDigit == DIGIT_W'(i));
    if (i > 0) begin : g_upper
      assign highHit = wrEn && wrConv && (wrDigit == DIGIT_W'(i - 1));
    end else begin : g_first
      assign highHit = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        stageBuf[4*i +: 4] <= 4'h0;
      else if (lowHit)
        stageBuf[4*i +: 4] <= wrConv ? pattern[3:0] : wrData;
      else if (highHit)
        stageBuf[4*i +: 4] <= pattern[7:4];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      dispBuf <= '0;
    else if (strobe.frameLoad)
      dispBuf <= stageBuf;
  end

  // Output levels
  lcdLevel_e selLvl;
  assign selLvl = strobe.negPhase ? LVL_LOW : LVL_HIGH;

  always_comb begin
    if (standby) begin
      com0Lvl = LVL_LOW;
      com1Lvl = LVL_LOW;
    end else begin
      com0Lvl = strobe.comSel ? LVL_MID : selLvl;
      com1Lvl = strobe.comSel ? selLvl : LVL_MID;
    end
  end

  for (genvar p = 0; p < NUM_SEG; p++) begin : g_seg
    assign segOut[p] = !standby && (dispBuf[2*p + strobe.comSel] ^ !strobe.negPhase);
  end

  // R7: the visible pattern holds between frame loads
  p_disp_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.frameLoad |=> $stable(dispBuf));

  // R2: outside standby exactly one common is away from mid
  p_one_selected_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !standby |-> ((com0Lvl == LVL_MID) != (com1Lvl == LVL_MID)));

endmodule

// File: rtl/lcdDuplexDriver.sv
module lcdDuplexDriver
  import lcdDuplexPkg::*;
#(
  parameter int NUM_SEG  = 23,
  parameter int TICK_HZ  = 1600,
  parameter int FRAME_HZ = 100,
  localparam int TICKS_PER_PHASE = TICK_HZ / (4 * FRAME_HZ),
  localparam int DIGIT_W = $clog2((2 * NUM_SEG + 3) / 4)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tickEn,
  input  logic               standby,
  input  logic               wrEn,
  input  logic               wrConv,
  input  logic [DIGIT_W-1:0] wrDigit,
  input  logic [3:0]         wrData,
  output logic [NUM_SEG-1:0] segOut,
  output logic [1:0]         com0Lvl,
  output logic [1:0]         com1Lvl
);

  lcdStrobe_t strobe;

  lcdDuplexCtrl #(.TICKS_PER_PHASE(TICKS_PER_PHASE)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .tickEn (tickEn),
    .strobe (strobe)
  );

  lcdDuplexData #(.NUM_SEG(NUM_SEG)) u_data (
    .clk     (clk),
    .rst_n   (rst_n),
    .standby (standby),
    .wrEn    (wrEn),
    .wrConv  (wrConv),
    .wrDigit (wrDigit),
    .wrData  (wrData),
    .strobe  (strobe),
    .segOut  (segOut),
    .com0Lvl (com0Lvl),
    .com1Lvl (com1Lvl)
  );

endmodule

// File: tb/lcdDuplexDriver_test.sv
module lcdDuplexDriver_test;

  localparam int CLK_PERIOD = 10;
  localparam int TPP        = 4;   // 1600 / (4 * 100)
  localparam int NSEG       = 23;
  localparam int NDIG       = 12;

  typedef struct packed {
    logic       conv;
    logic [3:0] digit;
    logic [3:0] value;
  } wrVec_t;

  // Writes walked by the main loop
  localparam wrVec_t VEC [8] = '{
    '{1'b0, 4'd0,  4'hA},   // R4 direct
    '{1'b0, 4'd5,  4'h3},   // R4 direct
    '{1'b1, 4'd2,  4'h8},   // R5 decoded
    '{1'b1, 4'd7,  4'h1},   // R5 decoded
    '{1'b0, 4'd3,  4'hF},   // R4 direct over decoded upper half
    '{1'b1, 4'd11, 4'h6},   // R6 top digit, upper half dropped
    '{1'b0, 4'd12, 4'hF},   // R6 out of range, ignored
    '{1'b1, 4'd0,  4'h0}    // R5 decoded zero
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tickEn = 1'b0;
  logic       standby = 1'b0;
  logic       wrEn = 1'b0;
  logic       wrConv = 1'b0;
  logic [3:0] wrDigit = '0;
  logic [3:0] wrData = '0;
  logic [NSEG-1:0] segOut;
  logic [1:0] com0Lvl;
  logic [1:0] com1Lvl;

  int checks = 0;
  int errors = 0;

  // Bench model
  logic [47:0] mStage = '0;
  logic [47:0] mDisp  = '0;
  int mTick  = 0;
  int mPhase = 0;
  bit mStby  = 0;

  lcdDuplexDriver uut (
    .clk(clk), .rst_n(rst_n), .tickEn(tickEn), .standby(standby),
    .wrEn(wrEn), .wrConv(wrConv), .wrDigit(wrDigit), .wrData(wrData),
    .segOut(segOut), .com0Lvl(com0Lvl), .com1Lvl(com1Lvl)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [6:0] sevenSeg(input logic [3:0] v);
    logic [6:0] t [16] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07,
                           7'h7F, 7'h6F, 7'h77, 7'h7C, 7'h39, 7'h5E, 7'h79, 7'h71};
    return t[v];
  endfunction

  task automatic modelWrite(input logic c, input logic [3:0] d, input logic [3:0] v);
    logic [7:0] pat;
    pat = {1'b0, sevenSeg(v)};
    if (d < NDIG) begin
      for (int j = 0; j < 4; j++) mStage[4*d + j] = c ? pat[j] : v[j];
      if (c && (d + 1 < NDIG))
        for (int j = 0; j < 4; j++) mStage[4*d + 4 + j] = pat[4 + j];
    end
  endtask

  // One clock: drive at the falling edge, update the model at the rising edge
  task automatic cycle(input logic w, input logic c, input logic [3:0] d,
                       input logic [3:0] v, input logic t, input logic s);
    wrEn = w; wrConv = c; wrDigit = d; wrData = v; tickEn = t; standby = s;
    @(posedge clk);
    if (t) begin
      if (mTick == TPP - 1) begin
        mTick = 0;
        if (mPhase == 3) mDisp = mStage;
        mPhase = (mPhase + 1) % 4;
      end else begin
        mTick++;
      end
    end
    if (w) modelWrite(c, d, v);
    mStby = s;
    @(negedge clk);
    wrEn = 1'b0; tickEn = 1'b0;
  endtask

  task automatic tick1(); cycle(1'b0, 1'b0, 4'd0, 4'd0, 1'b1, mStby); endtask

  task automatic checkOut(input string tag);
    logic [NSEG-1:0] eSeg;
    logic [1:0] e0, e1;
    int c;
    bit neg;
    c = mPhase % 2;
    neg = (mPhase >= 2);
    if (mStby) begin
      eSeg = '0; e0 = 2'b00; e1 = 2'b00;
    end else begin
      e0 = (c == 0) ? (neg ? 2'b00 : 2'b10) : 2'b01;
      e1 = (c == 1) ? (neg ? 2'b00 : 2'b10) : 2'b01;
      for (int p = 0; p < NSEG; p++) eSeg[p] = neg ? mDisp[2*p + c] : ~mDisp[2*p + c];
    end
    checks++;
    if (segOut !== eSeg || com0Lvl !== e0 || com1Lvl !== e1) begin
      errors++;
      $display("FAIL %s: phase %0d seg=%h com0=%b com1=%b expected seg=%h com0=%b com1=%b",
               tag, mPhase, segOut, com0Lvl, com1Lvl, eSeg, e0, e1);
    end
  endtask

  // Tick to the start of the next frame, then check every phase of one frame
  task automatic runFrame(input string tag);
    do tick1(); while (!(mPhase == 0 && mTick == 0));
    checkOut(tag);
    for (int k = 0; k < 4 * TPP; k++) begin
      tick1();
      checkOut(tag);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checkOut("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    checkOut("R1 after reset");

    // R2/R3: blank panel walked through all phases and polarities
    for (int k = 0; k < 4 * TPP + 2; k++) begin
      tick1();
      checkOut("R2 phase walk");
    end
    // R2: idle cycles without tick hold the phase
    repeat (5) cycle(1'b0, 1'b0, 4'd0, 4'd0, 1'b0, 1'b0);
    checkOut("R2 hold without tick");

    // Vector table walk
    for (int i = 0; i < 8; i++) begin
      cycle(1'b1, VEC[i].conv, VEC[i].digit, VEC[i].value, 1'b0, 1'b0);
      checkOut("R7 write not yet visible");
      runFrame(VEC[i].conv ? "R5 R6 decoded write" : "R4 R6 direct write");
    end

    // R7: write in the same cycle as the last tick of phase 3
    while (!(mPhase == 3 && mTick == TPP - 1)) tick1();
    cycle(1'b1, 1'b0, 4'd1, 4'h5, 1'b1, 1'b0);
    checkOut("R7 boundary write deferred");
    for (int k = 0; k < 4 * TPP - 1; k++) begin
      tick1();
      checkOut("R7 old frame kept");
    end
    runFrame("R7 boundary write shown next frame");

    // R8: standby blanks everything while the timer runs
    cycle(1'b0, 1'b0, 4'd0, 4'd0, 1'b0, 1'b1);
    checkOut("R8 standby low");
    for (int k = 0; k < TPP + 1; k++) begin
      tick1();
      checkOut("R8 standby low while ticking");
    end
    cycle(1'b0, 1'b0, 4'd0, 4'd0, 1'b0, 1'b0);
    checkOut("R8 resume after standby");
    runFrame("R8 normal frame after standby");

    // R1: reset again blanks the display and restarts in phase 0
    rst_n = 1'b0;
    mStage = '0; mDisp = '0; mTick = 0; mPhase = 0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checkOut("R1 second reset");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule